// File: doc/BRIEF.md
# DVFS Load-Level Clock Selector

This block decides which clock source and which divider ratio drive the processor clock. When dynamic frequency scaling is switched on, a 2-bit current-level register names one of four load levels. Each level has its own source and divider settings. These settings are packed two levels per configuration word: the even level sits in the upper half-word and the odd level in the lower half-word. When scaling is switched off, the block ignores the level machinery and takes the source and divider from two static registers.

Software reaches every register through a single write/read port. A write lands on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the address is presented.

Changing the static source is also the way to retarget every level at once. Such a write is accepted only while scaling is off, and it copies the new source into all four level slots. The two registered outputs give the effective source and divider to the clock-generation logic that sits next to this block.

Top module: `dvfs_clk_selector`

## Requirements
- R1: After synchronous reset every register reads zero and both outputs `eff_src` and `eff_div` are zero.
- R2: With scaling off (mode bit 31 of offset 0x24 clear), `eff_src` equals bits [23:22] of the static-source word at offset 0x00 and `eff_div` equals bits [30:28] of the static-divider word at offset 0x04.
- R3: With scaling on, the level is bits [1:0] of offset 0x30; levels 0 and 1 take their settings from the word at 0x18, levels 2 and 3 from the word at 0x1C.
- R4: Inside a level's half-word the divider occupies bits [15:13] and the source bits [10:9]; levels 0 and 2 use the upper half (add 16 to every position), levels 1 and 3 the lower half.
- R5: A write to offset 0x00 while scaling is on leaves bits [23:22] unchanged and updates every other bit.
- R6: A write to offset 0x00 while scaling is off stores the word and copies its bits [23:22] into bits [10:9] and [26:25] of both configuration words.
- R7: The outputs are registered: a register write taking effect at one clock edge shows on `eff_src`/`eff_div` at the following edge, and the outputs stay constant while no write occurs.
- R8: Read data is registered one cycle after the address; offset 0x30 reads only bits [1:0], offset 0x24 reads only bit 31, and unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| eff_src | output | 2 | Effective clock source select |
| eff_div | output | 3 | Effective divider ratio |

## Verification
The bench steps through all four levels and checks each one. A design that swapped the upper and lower halves, or chose the wrong word, would output another level's source and divider. The bench writes the static source with scaling on and then with scaling off. A design that ignored the lock would change the source while scaling is active, and a design that skipped the copy into the slots would leave stale sources behind in the configuration words. The bench samples the outputs on the cycle right after a level write, where they must still hold the old values. This catches a selector that updates early or adds an extra register. A behavioural model is then compared on every cycle while random writes and reads run, including writes to unmapped offsets and stray high bits in the level and mode words.

// File: rtl/dvfs_sel_pkg.sv
package dvfs_sel_pkg;
  localparam int OFS_STAT_SRC = 'h00;
  localparam int OFS_STAT_DIV = 'h04;
  localparam int OFS_CFG_BASE = 'h18;
  localparam int OFS_MODE     = 'h24;
  localparam int OFS_LOAD     = 'h30;

  localparam int POS_STAT_SRC = 22;
  localparam int POS_STAT_DIV = 28;
  localparam int POS_MODE_EN  = 31;

  localparam int HALF_W       = 16;
  localparam int POS_SLOT_DIV = 13;
  localparam int POS_SLOT_SRC = 9;
endpackage

// File: rtl/dvfs_sel_regs.sv
module dvfs_sel_regs
  import dvfs_sel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 2,
  parameter int DIV_W  = 3,
  parameter int LVL_W  = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              dyn_en,
  output logic [LVL_W-1:0]                  load,
  output logic [SRC_W-1:0]                  stat_src,
  output logic [DIV_W-1:0]                  stat_div,
  output logic [(1<<LVL_W)-1:0][SRC_W-1:0]  slot_src,
  output logic [(1<<LVL_W)-1:0][DIV_W-1:0]  slot_div
);
  localparam int NLVL = 1 << LVL_W;
  localparam int NCFG = NLVL / 2;
  localparam logic [DATA_W-1:0] SRC_MASK =
    DATA_W'((1 << SRC_W) - 1) << POS_STAT_SRC;

  logic [DATA_W-1:0] src_q, div_q;
  logic [DATA_W-1:0] cfg_q [NCFG];
  logic              en_q;
  logic [LVL_W-1:0]  load_q;
  logic [DATA_W-1:0] rd_mux;
  logic              hit_src;

  assign hit_src = (addr == ADDR_W'(OFS_STAT_SRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      div_q  <= '0;
      en_q   <= 1'b0;
      load_q <= '0;
      for (int w = 0; w < NCFG; w++) cfg_q[w] <= '0;
    end else if (we) begin
      if (hit_src) begin
        if (en_q) begin
          src_q <= (wdata & ~SRC_MASK) | (src_q & SRC_MASK);
        end else begin
          src_q <= wdata;
          for (int w = 0; w < NCFG; w++)
            for (int h = 0; h < 2; h++)
              cfg_q[w][h*HALF_W+POS_SLOT_SRC +: SRC_W] <= wdata[POS_STAT_SRC +: SRC_W];
        end
      end
      if (addr == ADDR_W'(OFS_STAT_DIV)) div_q <= wdata;
      if (addr == ADDR_W'(OFS_MODE))     en_q <= wdata[POS_MODE_EN];
      if (addr == ADDR_W'(OFS_LOAD))     load_q <= wdata[LVL_W-1:0];
      for (int w = 0; w < NCFG; w++)
        if (addr == ADDR_W'(OFS_CFG_BASE + 4*w)) cfg_q[w] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_STAT_SRC)) rd_mux = src_q;
    if (addr == ADDR_W'(OFS_STAT_DIV)) rd_mux = div_q;
    if (addr == ADDR_W'(OFS_MODE))     rd_mux = DATA_W'(en_q) << POS_MODE_EN;
    if (addr == ADDR_W'(OFS_LOAD))     rd_mux = DATA_W'(load_q);
    for (int w = 0; w < NCFG; w++)
      if (addr == ADDR_W'(OFS_CFG_BASE + 4*w)) rd_mux = cfg_q[w];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign dyn_en   = en_q;
  assign load     = load_q;
  assign stat_src = src_q[POS_STAT_SRC +: SRC_W];
  assign stat_div = div_q[POS_STAT_DIV +: DIV_W];

  // Even levels sit in the upper half-word, odd levels in the lower one.
  for (genvar k = 0; k < NLVL; k++) begin : g_slot
    localparam int BASE = ((k % 2) == 0) ? HALF_W : 0;
    assign slot_src[k] = cfg_q[k/2][BASE+POS_SLOT_SRC +: SRC_W];
    assign slot_div[k] = cfg_q[k/2][BASE+POS_SLOT_DIV +: DIV_W];
  end

  // R5: static source field frozen while scaling is active
  assert_src_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (we && hit_src && en_q) |=> $stable(stat_src));

  // R6: a source write with scaling off retargets every level slot
  assert_src_fanout_R6: assert property (@(posedge clk) disable iff (rst)
    (we && hit_src && !en_q) |=>
      (slot_src == {NLVL{$past(wdata[POS_STAT_SRC +: SRC_W])}}));

  // R8: level register reads back only its own bits
  assert_load_narrow_R8: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(OFS_LOAD)) |=> (rdata[DATA_W-1:LVL_W] == '0));
endmodule

// File: rtl/dvfs_sel_pick.sv
module dvfs_sel_pick #(
  parameter int SRC_W = 2,
  parameter int DIV_W = 3,
  parameter int LVL_W = 2
) (
  input  logic                              dyn_en,
  input  logic [LVL_W-1:0]                  load,
  input  logic [SRC_W-1:0]                  stat_src,
  input  logic [DIV_W-1:0]                  stat_div,
  input  logic [(1<<LVL_W)-1:0][SRC_W-1:0]  slot_src,
  input  logic [(1<<LVL_W)-1:0][DIV_W-1:0]  slot_div,
  output logic [SRC_W-1:0]                  nxt_src,
  output logic [DIV_W-1:0]                  nxt_div
);
  always_comb begin
    if (dyn_en) begin
      nxt_src = slot_src[load];
      nxt_div = slot_div[load];
    end else begin
      nxt_src = stat_src;
      nxt_div = stat_div;
    end
  end
endmodule

// File: rtl/dvfs_clk_selector.sv
module dvfs_clk_selector #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 2,
  parameter int DIV_W  = 3,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SRC_W-1:0]  eff_src,
  output logic [DIV_W-1:0]  eff_div
);
  localparam int NLVL = 1 << LVL_W;

  logic                        dyn_en;
  logic [LVL_W-1:0]            load;
  logic [SRC_W-1:0]            stat_src, nxt_src;
  logic [DIV_W-1:0]            stat_div, nxt_div;
  logic [NLVL-1:0][SRC_W-1:0]  slot_src;
  logic [NLVL-1:0][DIV_W-1:0]  slot_div;
  logic                        we_q;

  dvfs_sel_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .DIV_W(DIV_W), .LVL_W(LVL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .dyn_en(dyn_en), .load(load), .stat_src(stat_src), .stat_div(stat_div),
    .slot_src(slot_src), .slot_div(slot_div)
  );

  dvfs_sel_pick #(
    .SRC_W(SRC_W), .DIV_W(DIV_W), .LVL_W(LVL_W)
  ) u_pick (
    .dyn_en(dyn_en), .load(load), .stat_src(stat_src), .stat_div(stat_div),
    .slot_src(slot_src), .slot_div(slot_div), .nxt_src(nxt_src), .nxt_div(nxt_div)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_src <= '0;
      eff_div <= '0;
      we_q    <= 1'b0;
    end else begin
      eff_src <= nxt_src;
      eff_div <= nxt_div;
      we_q    <= we;
    end
  end

  // R7: without writes in the last two cycles the outputs hold
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!we && !we_q) |=> ($stable(eff_src) && $stable(eff_div)));

  // R2: with scaling off the static divider reaches the output one cycle later
  assert_static_div_R2: assert property (@(posedge clk) disable iff (rst)
    !dyn_en |=> (eff_div == $past(stat_div)));
endmodule

// File: tb/dvfs_clk_selector_test.sv
module dvfs_clk_selector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  eff_src;
  logic [2:0]  eff_div;

  int errors = 0;
  int checks = 0;
  bit armed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dvfs_clk_selector uut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .eff_src(eff_src), .eff_div(eff_div)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned m_src, m_div, m_en, m_load;
  int unsigned m_cfg [2];
  int unsigned e_src, e_div, e_rd;

  function automatic int unsigned mdl_field(input int unsigned pos, input int unsigned w);
    int unsigned lvl, word, sh;
    lvl  = m_load;
    word = m_cfg[lvl / 2];
    sh   = (lvl % 2 == 0) ? 16 : 0;
    return (word >> (sh + pos)) & ((1 << w) - 1);
  endfunction

  function automatic int unsigned mdl_read(input int unsigned a);
    case (a)
      'h00: return m_src;
      'h04: return m_div;
      'h18: return m_cfg[0];
      'h1C: return m_cfg[1];
      'h24: return m_en << 31;
      'h30: return m_load;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_src = 0; m_div = 0; m_en = 0; m_load = 0; m_cfg[0] = 0; m_cfg[1] = 0;
      e_src = 0; e_div = 0; e_rd = 0;
      armed = 1;
    end else begin
      e_src = m_en ? mdl_field(9, 2)  : (m_src >> 22) & 3;
      e_div = m_en ? mdl_field(13, 3) : (m_div >> 28) & 7;
      e_rd  = mdl_read(addr);
      if (we) begin
        case (addr)
          'h00: begin
            if (m_en != 0) m_src = (wdata & ~32'h00C0_0000) | (m_src & 32'h00C0_0000);
            else begin
              m_src = wdata;
              for (int w = 0; w < 2; w++)
                m_cfg[w] = (m_cfg[w] & ~32'h0600_0600) |
                           (((wdata >> 22) & 3) << 25) | (((wdata >> 22) & 3) << 9);
            end
          end
          'h04: m_div = wdata;
          'h18: m_cfg[0] = wdata;
          'h1C: m_cfg[1] = wdata;
          'h24: m_en = wdata[31];
          'h30: m_load = wdata & 3;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R7 outputs, R8 read data)
  always @(negedge clk) begin
    if (armed && !rst && !done) begin
      chk("R7 eff_src vs model", 32'(eff_src), e_src);
      chk("R7 eff_div vs model", 32'(eff_div), e_div);
      chk("R8 rdata vs model", rdata, e_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int exp_s [4] = '{2, 1, 3, 0};
    int exp_d [4] = '{5, 3, 6, 2};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 eff_src after reset", 32'(eff_src), 0);
    chk("R1 eff_div after reset", 32'(eff_div), 0);
    rd('h18, v); chk("R1 cfg word reset", v, 0);

    wr('h00, 32'h0040_0000);
    wr('h04, 32'h4000_0000);
    wr('h18, 32'hA400_6200);
    wr('h1C, 32'hC600_4000);
    @(negedge clk);
    chk("R2 static src", 32'(eff_src), 1);
    chk("R2 static div", 32'(eff_div), 4);

    wr('h24, 32'h8000_0000);
    for (int l = 0; l < 4; l++) begin
      wr('h30, 32'(l));
      @(negedge clk);
      chk("R3 level src", 32'(eff_src), 32'(exp_s[l]));
      chk("R4 level div", 32'(eff_div), 32'(exp_d[l]));
    end

    wr('h30, 0);
    chk("R7 output not yet updated", 32'(eff_src), 0);
    @(negedge clk);
    chk("R7 output updated next edge", 32'(eff_src), 2);

    wr('h00, 32'h00C0_00FF);
    rd('h00, v); chk("R5 locked source field", v, 32'h0040_00FF);
    chk("R5 output unchanged", 32'(eff_src), 2);

    wr('h24, 0);
    @(negedge clk);
    chk("R2 static src again", 32'(eff_src), 1);
    wr('h00, 32'h0080_0000);
    rd('h18, v); chk("R6 fanout word 0x18", v, 32'hA400_6400);
    rd('h1C, v); chk("R6 fanout word 0x1C", v, 32'hC400_4400);
    chk("R6 static src output", 32'(eff_src), 2);

    wr('h30, 32'hFFFF_FFFF);
    rd('h30, v); chk("R8 level reg narrow", v, 3);
    wr('h24, 32'hFFFF_FFFF);
    rd('h24, v); chk("R8 mode reg narrow", v, 32'h8000_0000);
    wr('h08, 32'h1234_5678);
    rd('h08, v); chk("R8 unmapped reads zero", v, 0);
    @(negedge clk);
    chk("R3 level 3 src", 32'(eff_src), 2);
    chk("R4 level 3 div", 32'(eff_div), 2);

    for (int i = 0; i < 1500; i++) begin
      logic [7:0] alist [8] = '{'h00, 'h04, 'h18, 'h1C, 'h24, 'h30, 'h08, 'h3C};
      @(negedge clk);
      we    = ($urandom % 3) == 0;
      addr  = alist[$urandom % 8];
      wdata = $urandom;
    end
    @(negedge clk); we = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule